// File: doc/BRIEF.md
# UART Interrupt Identification and Transmit Queue Entry

This block sits beside one UART channel and decides what that channel's single interrupt line says. Five conditions can raise it: a receive error, received data waiting, a receive idle time-out, a drained transmit queue and a modem-line change. Each condition is masked by its own bit in an 8-bit enable register that software writes and reads back. When more than one condition is eligible, the block reports the most urgent one as a fixed 8-bit identification code. It drives the interrupt request whenever any code other than "nothing pending" is shown.

Each condition has its own way of being acknowledged. A read of the line-status register clears the error flag, and a read of the modem-status register clears the modem flag. The transmit-empty flag clears when a status read reports it, or when software writes a new byte. The idle time-out flag clears when a byte is taken from the receive FIFO. The enable register also holds three extra enables, for software flow control, RTS/DTR change and CTS/DSR change, which are stored for software. Bytes written to the transmit holding port enter a small FIFO that the serial shifter drains one byte at a time.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable readback is 00h, the status code is C1h, the interrupt line is 0, the transmit queue reports empty and not full, and the transmit-empty flag is clear.
- R2: An enable write stores bits 0 to 6 (bit0 rx data, bit1 tx empty, bit2 rx line error, bit3 modem, bit4 soft flow, bit5 RTS/DTR, bit6 CTS/DSR) and they read back unchanged; bit7 always reads 0.
- R3: Status bits 7 and 6 always read 1. Status bit0 is 0 exactly when an interrupt is pending, and the interrupt line equals the inverse of status bit0.
- R4: A condition counts only when its flag and its enable are both 1. Enable bit0 gates both rx data and time-out, bit1 gates tx empty, bit2 gates rx error and bit3 gates modem. Bits 4 to 6 never change the status.
- R5: Priority, highest first: rx error C6h, rx data available C4h, rx time-out CCh, tx empty C2h, modem change C0h. With nothing eligible the code is C1h.
- R6: An rx error pulse sets the error flag. A line-status read clears it, unless a new error pulse arrives in the same cycle.
- R7: A modem-change pulse sets the modem flag. A modem-status read clears it, unless a new pulse arrives in the same cycle.
- R8: The tx-empty flag sets when a pop removes the last queued byte. A holding-register write clears it. A status read clears it only when that read reports C2h.
- R9: While the rx FIFO holds data and no byte is pushed or popped, the fourth character tick sets the time-out flag. A push restarts the count, and a pop clears both the count and the flag.
- R10: Bytes written to the holding port leave the transmit queue in write order, and the head byte is presented on the data output.
- R11: A holding-port write made while the queue holds DEPTH (16) bytes is discarded and the queue contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register readback |
| stat_rd | input | 1 | Status register read strobe |
| line_rd | input | 1 | Line-status register read strobe |
| mdm_rd | input | 1 | Modem-status register read strobe |
| rx_err_pulse | input | 1 | Receive error event |
| rx_ready | input | 1 | Receive data available level |
| rx_push | input | 1 | A byte entered the receive FIFO |
| rx_pop | input | 1 | A byte was taken from the receive FIFO |
| rx_has_data | input | 1 | Receive FIFO not empty |
| char_tick | input | 1 | One pulse per character time |
| mdm_pulse | input | 1 | Modem line change event |
| hold_wr | input | 1 | Transmit holding register write strobe |
| hold_wdata | input | 8 | Transmit holding register data |
| tx_take | input | 1 | Shifter takes the head byte |
| tx_head | output | 8 | Head byte of the transmit queue |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| stat_code | output | 8 | Interrupt identification code |
| irq | output | 1 | Interrupt request, active high |

## Verification
The idle time-out is the hardest case to reach. It needs the rx FIFO to stay non-empty across four character ticks with no push or pop in between, and random pulses rarely leave that gap. A directed run holds the FIFO non-empty and issues ticks one at a time. The status is checked after the third tick, which must show no time-out, and after the fourth, which must show CCh. A further directed run fills the transmit queue to its full depth, writes once more, and then drains it to confirm order and that the extra byte was dropped.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam logic [7:0] ST_NONE  = 8'hC1;
    localparam logic [7:0] ST_RXERR = 8'hC6;
    localparam logic [7:0] ST_RXAVL = 8'hC4;
    localparam logic [7:0] ST_RXTMO = 8'hCC;
    localparam logic [7:0] ST_TXEMP = 8'hC2;
    localparam logic [7:0] ST_MODEM = 8'hC0;

    typedef struct packed {
        logic rx_err;
        logic rx_avail;
        logic rx_tmo;
        logic tx_emp;
        logic modem;
    } irq_src_t;

    typedef struct packed {
        logic rsv;
        logic cts_dsr;
        logic rts_dtr;
        logic swflow;
        logic modem;
        logic rx_line;
        logic tx_emp;
        logic rx_data;
    } en_reg_t;

    function automatic irq_src_t gate_src(irq_src_t f, en_reg_t e);
        irq_src_t g;
        g.rx_err   = f.rx_err   & e.rx_line;
        g.rx_avail = f.rx_avail & e.rx_data;
        g.rx_tmo   = f.rx_tmo   & e.rx_data;
        g.tx_emp   = f.tx_emp   & e.tx_emp;
        g.modem    = f.modem    & e.modem;
        return g;
    endfunction

    function automatic logic [7:0] prio_code(irq_src_t p);
        if (p.rx_err)        return ST_RXERR;
        else if (p.rx_avail) return ST_RXAVL;
        else if (p.rx_tmo)   return ST_RXTMO;
        else if (p.tx_emp)   return ST_TXEMP;
        else if (p.modem)    return ST_MODEM;
        else                 return ST_NONE;
    endfunction

endpackage

// File: rtl/irq_txq.sv
module irq_txq #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic         pop_to_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty        = (cnt == '0);
    assign full         = (cnt == CW'(DEPTH));
    assign do_push      = wr && !full;
    assign do_pop       = rd && !empty;
    assign pop_to_empty = do_pop && !do_push && (cnt == CW'(1));
    assign rdata        = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)) else $error("queue count above depth"); // R11
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !rd) |=> (full && $stable(wp))) else $error("write while full changed queue"); // R11

endmodule

// File: rtl/irq_rx_timer.sv
module irq_rx_timer #(
    parameter int CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  logic has_data,
    input  logic tick,
    output logic tmo
);
    localparam int TW = $clog2(CHARS + 1);

    logic [TW-1:0] idle;
    logic          restart, hit;

    assign restart = push || pop || !has_data;
    assign hit     = !restart && tick && (idle == TW'(CHARS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idle <= '0;
            tmo  <= 1'b0;
        end else begin
            if (restart)                           idle <= '0;
            else if (tick && idle < TW'(CHARS))    idle <= idle + 1'b1;
            if (pop)      tmo <= 1'b0;
            else if (hit) tmo <= 1'b1;
        end
    end

    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        pop |=> !tmo) else $error("time-out survived a pop"); // R9
    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo) |-> $past(has_data)) else $error("time-out without data"); // R9

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  irq_src_t   flags,
    input  en_reg_t    en,
    output logic [7:0] code
);
    irq_src_t eligible;

    always_comb begin
        eligible = gate_src(flags, en);
        code     = prio_code(eligible);
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int TXQ_DEPTH = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  logic [7:0] en_wdata,
    output logic [7:0] en_rdata,
    input  logic       stat_rd,
    input  logic       line_rd,
    input  logic       mdm_rd,
    input  logic       rx_err_pulse,
    input  logic       rx_ready,
    input  logic       rx_push,
    input  logic       rx_pop,
    input  logic       rx_has_data,
    input  logic       char_tick,
    input  logic       mdm_pulse,
    input  logic       hold_wr,
    input  logic [7:0] hold_wdata,
    input  logic       tx_take,
    output logic [7:0] tx_head,
    output logic       tx_empty,
    output logic       tx_full,
    output logic [7:0] stat_code,
    output logic       irq
);
    en_reg_t  en_q;
    logic     err_q, mdm_q, txe_q;
    logic     tmo;
    logic     pop_to_empty;
    irq_src_t flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q     <= en_reg_t'(en_wdata);
            en_q.rsv <= 1'b0;
        end
    end
    assign en_rdata = en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
            mdm_q <= 1'b0;
            txe_q <= 1'b0;
        end else begin
            if (rx_err_pulse) err_q <= 1'b1;
            else if (line_rd) err_q <= 1'b0;
            if (mdm_pulse)    mdm_q <= 1'b1;
            else if (mdm_rd)  mdm_q <= 1'b0;
            if (hold_wr)                              txe_q <= 1'b0;
            else if (pop_to_empty)                    txe_q <= 1'b1;
            else if (stat_rd && stat_code == ST_TXEMP) txe_q <= 1'b0;
        end
    end

    irq_rx_timer #(.CHARS(TMO_CHARS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .push     (rx_push),
        .pop      (rx_pop),
        .has_data (rx_has_data),
        .tick     (char_tick),
        .tmo      (tmo)
    );

    irq_txq #(.DEPTH(TXQ_DEPTH), .W(8)) u_txq (
        .clk          (clk),
        .rst          (rst),
        .wr           (hold_wr),
        .wdata        (hold_wdata),
        .rd           (tx_take),
        .rdata        (tx_head),
        .empty        (tx_empty),
        .full         (tx_full),
        .pop_to_empty (pop_to_empty)
    );

    always_comb begin
        flags.rx_err   = err_q;
        flags.rx_avail = rx_ready;
        flags.rx_tmo   = tmo;
        flags.tx_emp   = txe_q;
        flags.modem    = mdm_q;
    end

    irq_prio_enc u_enc (
        .flags (flags),
        .en    (en_q),
        .code  (stat_code)
    );

    assign irq = ~stat_code[0];

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_rdata[3:0] != 4'b0)) else $error("irq with sources masked"); // R4
    AST_STAT_FIXED: assert property (@(posedge clk) disable iff (rst)
        stat_code[7:6] == 2'b11) else $error("status top bits not set"); // R3
    AST_ERR_ACK: assert property (@(posedge clk) disable iff (rst)
        (line_rd && !rx_err_pulse) |=> !err_q) else $error("error flag kept after line read"); // R6
    AST_MDM_ACK: assert property (@(posedge clk) disable iff (rst)
        (mdm_rd && !mdm_pulse) |=> !mdm_q) else $error("modem flag kept after modem read"); // R7
    AST_TXE_WR: assert property (@(posedge clk) disable iff (rst)
        hold_wr |=> (stat_code != ST_TXEMP)) else $error("tx empty shown after write"); // R8
    AST_EN_RSV: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> !en_rdata[7]) else $error("reserved enable bit stored"); // R2

endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_wr = 0, stat_rd = 0, line_rd = 0, mdm_rd = 0;
    logic [7:0] en_wdata = 0, hold_wdata = 0;
    logic       rx_err_pulse = 0, rx_ready = 0, rx_push = 0, rx_pop = 0;
    logic       rx_has_data = 0, char_tick = 0, mdm_pulse = 0;
    logic       hold_wr = 0, tx_take = 0;
    logic [7:0] en_rdata, tx_head, stat_code;
    logic       tx_empty, tx_full, irq;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [7:0] m_en;
    logic       m_err, m_mdm, m_txe, m_tmo;
    int         m_idle;
    logic [7:0] m_q [16];
    int         m_wp, m_rp, m_cnt;

    always #4 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .stat_rd(stat_rd), .line_rd(line_rd), .mdm_rd(mdm_rd),
        .rx_err_pulse(rx_err_pulse), .rx_ready(rx_ready), .rx_push(rx_push),
        .rx_pop(rx_pop), .rx_has_data(rx_has_data), .char_tick(char_tick),
        .mdm_pulse(mdm_pulse), .hold_wr(hold_wr), .hold_wdata(hold_wdata),
        .tx_take(tx_take), .tx_head(tx_head), .tx_empty(tx_empty), .tx_full(tx_full),
        .stat_code(stat_code), .irq(irq)
    );

    function automatic logic [7:0] exp_code();
        if (m_en[2] && m_err)         return 8'hC6;
        else if (m_en[0] && rx_ready) return 8'hC4;
        else if (m_en[0] && m_tmo)    return 8'hCC;
        else if (m_en[1] && m_txe)    return 8'hC2;
        else if (m_en[3] && m_mdm)    return 8'hC0;
        else                          return 8'hC1;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_err = 0; m_mdm = 0; m_txe = 0; m_tmo = 0; m_idle = 0;
        m_wp = 0; m_rp = 0; m_cnt = 0;
    endtask

    task automatic compare_all();
        chk("R5 status code", stat_code, exp_code());
        chk("R3 irq", {7'b0, irq}, {7'b0, exp_code() != 8'hC1});
        chk("R2 enable readback", en_rdata, m_en);
        chk("R11 full/empty", {6'b0, tx_full, tx_empty}, {6'b0, m_cnt == 16, m_cnt == 0});
        if (m_cnt > 0) chk("R10 head byte", tx_head, m_q[m_rp]);
    endtask

    // one clock cycle with the present inputs, model updated alongside
    task automatic cyc();
        logic [7:0] code_now;
        logic       push, pop, restart;
        code_now = exp_code();
        push = hold_wr && m_cnt < 16;
        pop  = tx_take && m_cnt > 0;
        @(posedge clk); #1;
        if (en_wr) m_en = en_wdata & 8'h7F;
        if (rx_err_pulse) m_err = 1; else if (line_rd) m_err = 0;
        if (mdm_pulse) m_mdm = 1; else if (mdm_rd) m_mdm = 0;
        if (hold_wr) m_txe = 0;
        else if (pop && !push && m_cnt == 1) m_txe = 1;
        else if (stat_rd && code_now == 8'hC2) m_txe = 0;
        restart = rx_push || rx_pop || !rx_has_data;
        if (rx_pop) m_tmo = 0;
        else if (!restart && char_tick && m_idle == 3) m_tmo = 1;
        if (restart) m_idle = 0; else if (char_tick && m_idle < 4) m_idle++;
        if (push) begin m_q[m_wp] = hold_wdata; m_wp = (m_wp + 1) % 16; end
        if (pop) m_rp = (m_rp + 1) % 16;
        m_cnt = m_cnt + (push ? 1 : 0) - (pop ? 1 : 0);
        en_wr = 0; stat_rd = 0; line_rd = 0; mdm_rd = 0; rx_err_pulse = 0;
        rx_push = 0; rx_pop = 0; char_tick = 0; mdm_pulse = 0; hold_wr = 0; tx_take = 0;
        compare_all();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 enable reset", en_rdata, 8'h00);
        chk("R1 status reset", stat_code, 8'hC1);
        chk("R1 irq reset", {7'b0, irq}, 8'h00);
        chk("R1 queue reset", {6'b0, tx_full, tx_empty}, 8'h01);

        // R2 readback, reserved bit
        en_wdata = 8'hFF; en_wr = 1; cyc();
        chk("R2 bit7 zero", en_rdata, 8'h7F);
        // R4 extra enables alone leave status idle while modem flag set
        en_wdata = 8'h70; en_wr = 1; mdm_pulse = 1; cyc();
        chk("R4 extra enables no effect", stat_code, 8'hC1);
        en_wdata = 8'h08; en_wr = 1; cyc();
        chk("R7 modem code", stat_code, 8'hC0);
        mdm_rd = 1; mdm_pulse = 1; cyc();
        chk("R7 same-cycle pulse wins", stat_code, 8'hC0);
        mdm_rd = 1; cyc();
        chk("R7 modem cleared", stat_code, 8'hC1);

        // R5 priority stack: all sources on
        en_wdata = 8'h0F; en_wr = 1; rx_err_pulse = 1; mdm_pulse = 1; rx_ready = 1; cyc();
        chk("R5 error highest", stat_code, 8'hC6);
        line_rd = 1; cyc();
        chk("R6 error cleared", stat_code, 8'hC4);
        rx_ready = 0; cyc();
        chk("R5 modem lowest", stat_code, 8'hC0);
        mdm_rd = 1; cyc();

        // R9 time-out: three ticks not enough, fourth sets
        rx_has_data = 1; cyc();
        for (int i = 0; i < 3; i++) begin char_tick = 1; cyc(); end
        chk("R9 no time-out after 3", stat_code, 8'hC1);
        rx_push = 1; char_tick = 1; cyc();
        for (int i = 0; i < 3; i++) begin char_tick = 1; cyc(); end
        chk("R9 push restarted count", stat_code, 8'hC1);
        char_tick = 1; cyc();
        chk("R9 time-out set", stat_code, 8'hCC);
        rx_pop = 1; cyc();
        chk("R9 pop clears", stat_code, 8'hC1);
        rx_has_data = 0; cyc();

        // R10 R11 fill to full, extra write dropped, drain in order
        for (int i = 0; i < 17; i++) begin hold_wr = 1; hold_wdata = 8'(8'h30 + i); cyc(); end
        chk("R11 full after 16", {7'b0, tx_full}, 8'h01);
        for (int i = 0; i < 16; i++) begin
            chk("R10 drain order", tx_head, 8'(8'h30 + i));
            tx_take = 1; cyc();
        end
        chk("R11 extra write dropped", {7'b0, tx_empty}, 8'h01);
        chk("R8 empty flag set", stat_code, 8'hC2);
        mdm_pulse = 1; cyc();
        stat_rd = 1; cyc();
        chk("R8 read reporting C2 clears", stat_code, 8'hC0);
        hold_wr = 1; hold_wdata = 8'h55; cyc();
        tx_take = 1; rx_err_pulse = 1; cyc();
        stat_rd = 1; cyc();
        chk("R8 read of other code keeps flag", {7'b0, m_txe}, 8'h01);
        line_rd = 1; cyc();
        chk("R8 flag still shown", stat_code, 8'hC2);
        mdm_rd = 1; hold_wr = 1; hold_wdata = 8'hAA; cyc();
        chk("R8 write clears", stat_code, 8'hC1);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            en_wr        = ($urandom % 20) == 0;
            en_wdata     = 8'($urandom);
            stat_rd      = ($urandom % 6) == 0;
            line_rd      = ($urandom % 10) == 0;
            mdm_rd       = ($urandom % 10) == 0;
            rx_err_pulse = ($urandom % 25) == 0;
            mdm_pulse    = ($urandom % 20) == 0;
            if (($urandom % 30) == 0) rx_ready = ~rx_ready;
            if (($urandom % 40) == 0) rx_has_data = ~rx_has_data;
            rx_push      = ($urandom % 24) == 0;
            rx_pop       = ($urandom % 24) == 0;
            char_tick    = ($urandom % 3) == 0;
            hold_wr      = ($urandom % 4) == 0;
            hold_wdata   = 8'($urandom);
            tx_take      = ($urandom % 4) == 0;
            cyc();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule